// File: doc/BRIEF.md
# CRC-4 Interworking Timeout Monitor

This block sits beside the receive side of an E1 framer and decides whether the far end transmits CRC-4 at all. The framer provides a strobe once per received E1 frame, a level saying that basic frame alignment is held, and a level saying that CRC-4 multiframe alignment has been reached. While monitoring is enabled, the block counts frames during which basic framing holds but multiframe alignment has not been found. If that count reaches a fixed limit, the block decides that the remote equipment does not generate CRC-4.

The default limit is 3200 frames. At 125 us per frame, this is 400 ms. The limit is a parameter. When the limit is reached, a live status output goes high and stays high while the qualifying condition lasts. On the rising edge of that status, a sticky interrupt flag is set. The flag stays high until a clear pulse is applied.

Every pin is a plain control or status level. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `crc4_iw_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `remote_no_crc` and `irq_flag` are 0, and the frame counter is zero.
- R2: While `mon_en` is 0, `remote_no_crc` is 0. Clearing `mon_en` also resets the frame counter, so no declaration and no interrupt can result.
- R3: `remote_no_crc` rises in the same cycle as the clock edge that registers the LIMIT-th qualifying `frame_tick`. It does not rise after LIMIT-1 ticks. A qualifying tick is one that arrives while `mon_en`=1, `fas_lock`=1 and `mf_lock`=0.
- R4: Ticks seen while `fas_lock`=0 are not counted. Losing basic alignment resets the counter, so LIMIT fresh qualifying ticks are needed after alignment returns.
- R5: When `mf_lock` is 1, the counter resets and `remote_no_crc` is 0. Multiframe alignment that arrives before expiry therefore prevents the declaration.
- R6: `remote_no_crc` follows the live condition. It falls in the same cycle that `mon_en` falls, `fas_lock` falls or `mf_lock` rises.
- R7: `irq_flag` goes to 1 one clock after `remote_no_crc` rises. It then stays at 1, even after the status falls, until a clear.
- R8: A cycle with `irq_clear`=1 sets `irq_flag` to 0 at the next edge. The exception is when `remote_no_crc` rises in that same cycle: setting takes precedence. A status that is held high does not set the flag again after a clear.
- R9: After expiry, the counter saturates at LIMIT. Further qualifying ticks keep `remote_no_crc` at 1 and never wrap it back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Enables interworking monitoring |
| frame_tick | input | 1 | One-cycle strobe per received E1 frame (the timebase) |
| fas_lock | input | 1 | Basic frame alignment is held |
| mf_lock | input | 1 | CRC-4 multiframe alignment is achieved |
| irq_clear | input | 1 | Pulse that clears the sticky interrupt flag |
| remote_no_crc | output | 1 | Live status: the remote end is treated as non-CRC-4 |
| irq_flag | output | 1 | Sticky interrupt, set on the rise of `remote_no_crc` |

## Verification
The bench counts exactly LIMIT-1 and LIMIT qualifying ticks. A design with an off-by-one error would declare one frame early or one frame late. It drops basic framing partway through a count and then expects a full LIMIT after recovery; a timer that only pauses would expire too soon. It raises multiframe alignment one tick before the limit, and clears the interrupt while the status is held and also on the very cycle it rises. A level-triggered or clear-dominant flag would either re-fire or lose the event. Long runs of ticks past expiry, with monitoring disabled, show any counter that wraps or any declaration that leaks through.

// File: rtl/crc4_iw_pkg.sv
package crc4_iw_pkg;
  // Bits needed to hold values 0..lim inclusive.
  function automatic int cnt_bits(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/crc4_iw_timer.sv
module crc4_iw_timer #(
  parameter int LIMIT = 3200,
  parameter int CW    = crc4_iw_pkg::cnt_bits(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          qualify,
  output logic          at_limit
);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] count;

  // Any break in the qualifying condition restarts the wait from zero.
  always_ff @(posedge clk) begin
    if (!rst_n)                count <= '0;
    else if (!qualify)         count <= '0;
    else if (tick && !at_limit) count <= count + 1'b1;
  end

  assign at_limit = (count == LIM_V);
endmodule

// File: rtl/crc4_iw_flag.sv
module crc4_iw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic declare,
  input  logic clear,
  output logic irq
);
  logic declare_q;
  logic set_evt;

  assign set_evt = declare && !declare_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      declare_q <= 1'b0;
      irq       <= 1'b0;
    end else begin
      declare_q <= declare;
      // A new event outranks a clear in the same cycle.
      if (set_evt)    irq <= 1'b1;
      else if (clear) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/crc4_iw_monitor.sv
module crc4_iw_monitor #(
  parameter int LIMIT = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic frame_tick,
  input  logic fas_lock,
  input  logic mf_lock,
  input  logic irq_clear,
  output logic remote_no_crc,
  output logic irq_flag
);
  localparam int CW = crc4_iw_pkg::cnt_bits(LIMIT);

  logic qualify;
  logic at_limit;

  assign qualify = mon_en && fas_lock && !mf_lock;

  crc4_iw_timer #(.LIMIT(LIMIT), .CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (frame_tick),
    .qualify  (qualify),
    .at_limit (at_limit)
  );

  // Status is live: gated by the current qualifying condition.
  assign remote_no_crc = at_limit && qualify;

  crc4_iw_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .declare (remote_no_crc),
    .clear   (irq_clear),
    .irq     (irq_flag)
  );
endmodule

// File: rtl/crc4_iw_monitor_chk.sv
module crc4_iw_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic frame_tick,
  input logic fas_lock,
  input logic mf_lock,
  input logic irq_clear,
  input logic remote_no_crc,
  input logic irq_flag
);
  p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> !remote_no_crc);

  p_no_fas_no_decl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fas_lock |-> !remote_no_crc);

  p_mf_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mf_lock |-> !remote_no_crc);

  p_irq_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remote_no_crc) |=> irq_flag);

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clear) |=> irq_flag);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(remote_no_crc));

  p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !$rose(remote_no_crc)) |=> !irq_flag);

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_no_crc && mon_en && fas_lock && !mf_lock) |=> 
      (remote_no_crc || !(mon_en && fas_lock && !mf_lock)));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!remote_no_crc && !irq_flag));
endmodule

bind crc4_iw_monitor crc4_iw_monitor_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mon_en        (mon_en),
  .frame_tick    (frame_tick),
  .fas_lock      (fas_lock),
  .mf_lock       (mf_lock),
  .irq_clear     (irq_clear),
  .remote_no_crc (remote_no_crc),
  .irq_flag      (irq_flag)
);

// File: tb/crc4_iw_monitor_bench.sv
module crc4_iw_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en = 1'b0, frame_tick = 1'b0, fas_lock = 1'b0, mf_lock = 1'b0, irq_clear = 1'b0;
  logic remote_no_crc, irq_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, derived from the requirements.
  int m_cnt = 0;
  bit m_irq = 1'b0;
  bit m_stq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc4_iw_monitor #(.LIMIT(LIM)) u_crc4_iw_monitor (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .frame_tick(frame_tick),
    .fas_lock(fas_lock), .mf_lock(mf_lock), .irq_clear(irq_clear),
    .remote_no_crc(remote_no_crc), .irq_flag(irq_flag)
  );

  function automatic bit qual(bit en, bit ba, bit mf);
    return en && ba && !mf;
  endfunction

  function automatic bit exp_status(int cnt, bit en, bit ba, bit mf);
    return (cnt == LIM) && qual(en, ba, mf);
  endfunction

  function automatic int next_cnt(int cnt, bit tk, bit en, bit ba, bit mf);
    if (!qual(en, ba, mf)) return 0;
    if (tk && cnt < LIM) return cnt + 1;
    return cnt;
  endfunction

  task automatic chk(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, check, advance the model, wait for the rising edge.
  task automatic step(string tag, bit tk, bit en, bit ba, bit mf, bit clr);
    bit es;
    @(negedge clk);
    frame_tick = tk; mon_en = en; fas_lock = ba; mf_lock = mf; irq_clear = clr;
    #1;
    es = exp_status(m_cnt, en, ba, mf);
    chk(tag, "remote_no_crc", remote_no_crc, es);
    chk(tag, "irq_flag", irq_flag, m_irq);
    if (es && !m_stq) m_irq = 1'b1;
    else if (clr)     m_irq = 1'b0;
    m_stq = es;
    m_cnt = next_cnt(m_cnt, tk, en, ba, mf);
  endtask

  // n qualifying ticks, each followed by an idle cycle.
  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) begin
      step(tag, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
      step(tag, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "remote_no_crc in reset", remote_no_crc, 1'b0);
    chk("R1", "irq_flag in reset", irq_flag, 1'b0);
    rst_n = 1'b1;
    m_cnt = 0; m_irq = 1'b0; m_stq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c4a1));
    do_reset();
    step("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2: disabled, many ticks with framing held.
    for (int i = 0; i < 3*LIM; i++) step("R2", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

    // R3: exactly LIMIT-1 ticks gives no declaration, the LIMIT-th gives one.
    ticks("R3", LIM-1);
    chk("R3", "no decl at LIMIT-1", remote_no_crc, 1'b0);
    step("R3", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3", "decl at LIMIT", remote_no_crc, 1'b1);
    // R7: the flag rose one edge later and is checked in step.
    step("R7", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7", "irq set", irq_flag, 1'b1);
    // R9: ticks past expiry keep the status.
    ticks("R9", 2*LIM);
    chk("R9", "still declared", remote_no_crc, 1'b1);
    // R6 / R7: losing framing drops the status at once; the flag remains.
    step("R6", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R6", "status follows fas_lock", remote_no_crc, 1'b0);
    chk("R7", "irq sticky", irq_flag, 1'b1);
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8", "irq cleared", irq_flag, 1'b0);

    // R4: framing lost partway through the count restarts it.
    ticks("R4", LIM-2);
    for (int i = 0; i < 4; i++) step("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    ticks("R4", LIM-1);
    chk("R4", "no early decl after restart", remote_no_crc, 1'b0);
    ticks("R4", 1);
    chk("R4", "decl after full restart", remote_no_crc, 1'b1);

    // R8: clear while status is held does not re-set the flag.
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R8", "held status no re-set", irq_flag, 1'b0);

    // R5: alignment one tick before the limit prevents the declaration.
    step("R5", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    ticks("R5", LIM-1);
    step("R5", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 2*LIM; i++) step("R5", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R5", "mf_lock prevents decl", remote_no_crc, 1'b0);
    chk("R5", "no irq", irq_flag, 1'b0);

    // R8: a clear in the cycle of the rise loses to the set.
    ticks("R8", LIM-1);
    step("R8", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R8", "set beats clear", irq_flag, 1'b1);
    // R2: clearing the enable drops the status at once.
    step("R2", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2", "status off when disabled", remote_no_crc, 1'b0);

    // Constrained random mix.
    for (int i = 0; i < 6000; i++) begin
      step("R3", 1'($urandom_range(0, 1)),
           ($urandom_range(0, 19) != 0),
           ($urandom_range(0, 29) != 0),
           ($urandom_range(0, 39) == 0),
           ($urandom_range(0, 24) == 0));
    end

    do_reset();
    step("R1", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule